// File: doc/BRIEF.md
# Controller Error Interrupt Collector

This block gathers six error event lines from a link controller into sticky status bits and raises one error interrupt. Each event arrives as a one-cycle pulse from logic outside the block. Once a bit is set, it stays set until software acknowledges it. A register port gives software two views of the same bits. The raw view shows every latched event, whatever the enables are. The status view shows only the latched events whose source is enabled.

Software turns sources on with one address and off with another, writing a one for each bit to change. It acknowledges events by writing ones to the status address. The usual service step is to read the raw view and write that same value back. The interrupt output is high while any enabled bit is latched. A second output, the fatal indicator, is high only while an enabled fatal-class bit is latched. The fatal class is the fatal-error bit and the tag-lookup fault bit.

Top module: `errirq_hub`

## Requirements
- R1: After reset all latched bits and all enables are zero, and both `err_irq_o` and `err_fatal_o` are low.
- R2: A pulse on `evt_i[k]` sets latched bit k at the next clock edge, whatever the enables are. The bit stays set while no acknowledge is written. Bit map: 0 summary system error, 1 fatal, 2 non-fatal, 3 correctable, 4 tag-lookup fault, 5 ECRC error.
- R3: A write to address 0x1C8 sets enable bit k for every `reg_wdata[k]` that is 1. Enable bits written as 0 keep their value.
- R4: A write to address 0x1CC clears enable bit k for every `reg_wdata[k]` that is 1. Enable bits written as 0 keep their value.
- R5: A read at 0x1C0 returns the latched bits. A read at 0x1C4 returns the latched bits AND the enables. Reads at 0x1C8 and 0x1CC both return the enable bits. The read data is combinational from the address.
- R6: A write to 0x1C4 clears latched bit k for every `reg_wdata[k]` that is 1. A write to 0x1C0 changes no latched bit.
- R7: An event pulse in the same cycle as an acknowledge of the same bit leaves that bit set.
- R8: `err_irq_o` is the OR of the latched bits AND the enables.
- R9: `err_fatal_o` is high only while latched bit 1 or latched bit 4 is set with its enable also set.
- R10: Read data bits 31:6 are always zero. A read at any other address returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_i | input | 6 | Error event pulses, one per source |
| reg_addr | input | 12 | Register byte address |
| reg_we | input | 1 | Write strobe for one cycle |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| err_irq_o | output | 1 | Error interrupt |
| err_fatal_o | output | 1 | Fatal-class error indicator |

## Verification
The assertions assume that `evt_i` and the register inputs are known values at every clock edge after reset. They also assume a write strobe targets only one address in a cycle, so an enable set and an enable clear can never meet. The stimulus changes inputs only on the falling edge. It always drives known values and issues at most one write per cycle. Random events are mixed with random writes to all four addresses and to one unmapped address. These sit alongside directed cases for an event meeting an acknowledge and for a read-back-and-write acknowledge.

// File: rtl/errirq_pkg.sv
`timescale 1ns/1ps
package errirq_pkg;
  localparam int unsigned SRC_N = 6;
  typedef logic [SRC_N-1:0] srcvec_t;

  // Sticky update: acknowledge clears, a new event wins over a clear.
  function automatic srcvec_t sticky_next(srcvec_t cur, srcvec_t evt, srcvec_t ack);
    return (cur & ~ack) | evt;
  endfunction

  // Enable update for one set and one clear vector.
  function automatic srcvec_t enable_next(srcvec_t cur, srcvec_t set, srcvec_t clr);
    return (cur | set) & ~clr;
  endfunction

  function automatic srcvec_t gate(srcvec_t raw, srcvec_t en);
    return raw & en;
  endfunction
endpackage

// File: rtl/errirq_bits.sv
`timescale 1ns/1ps
module errirq_bits
  import errirq_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  srcvec_t evt_i,
  input  srcvec_t ack_i,
  output srcvec_t raw_o
);
  srcvec_t raw_q;

  for (genvar g = 0; g < SRC_N; g++) begin : g_cell
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) raw_q[g] <= 1'b0;
      else        raw_q[g] <= (raw_q[g] & ~ack_i[g]) | evt_i[g];
    end
  end

  assign raw_o = raw_q;

  // R2 / R7: every pulsed source is latched on the following edge.
  a_r2_event_latches: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_i != '0) |=> ((raw_o & $past(evt_i)) == $past(evt_i)));

  // R6: acknowledged bits without a concurrent event drop.
  a_r6_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i != '0) |=> ((raw_o & $past(ack_i & ~evt_i)) == '0));

  // R2: with no event and no acknowledge, the bits hold.
  a_r2_sticky_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_i == '0 && ack_i == '0) |=> $stable(raw_o));
endmodule

// File: rtl/errirq_regs.sv
`timescale 1ns/1ps
module errirq_regs
  import errirq_pkg::*;
#(
  parameter int unsigned ADDR_W   = 12,
  parameter int unsigned DATA_W   = 32,
  parameter logic [ADDR_W-1:0] A_RAW  = 12'h1C0,
  parameter logic [ADDR_W-1:0] A_STAT = 12'h1C4,
  parameter logic [ADDR_W-1:0] A_ESET = 12'h1C8,
  parameter logic [ADDR_W-1:0] A_ECLR = 12'h1CC
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_we,
  input  logic [DATA_W-1:0] reg_wdata,
  input  srcvec_t           raw_i,
  output srcvec_t           en_o,
  output srcvec_t           ack_o,
  output logic [DATA_W-1:0] reg_rdata
);
  localparam int unsigned PAD_W = DATA_W - SRC_N;

  logic    hit_raw, hit_stat, hit_set, hit_clr;
  srcvec_t wbits, set_v, clr_v, en_q, rd_bits;
  logic    unused_wdata_hi;

  assign hit_raw  = (reg_addr == A_RAW);
  assign hit_stat = (reg_addr == A_STAT);
  assign hit_set  = (reg_addr == A_ESET);
  assign hit_clr  = (reg_addr == A_ECLR);

  assign wbits  = reg_wdata[SRC_N-1:0];
  assign unused_wdata_hi = ^reg_wdata[DATA_W-1:SRC_N];

  assign set_v = (reg_we && hit_set)  ? wbits : '0;
  assign clr_v = (reg_we && hit_clr)  ? wbits : '0;
  assign ack_o = (reg_we && hit_stat) ? wbits : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= '0;
    else        en_q <= enable_next(en_q, set_v, clr_v);
  end

  assign en_o = en_q;

  always_comb begin
    rd_bits = '0;
    if (hit_raw)              rd_bits = raw_i;
    else if (hit_stat)        rd_bits = gate(raw_i, en_q);
    else if (hit_set || hit_clr) rd_bits = en_q;
  end

  assign reg_rdata = {{PAD_W{1'b0}}, rd_bits};

  // R3: bits written to the set address are enabled next cycle.
  a_r3_enable_set: assert property (@(posedge clk) disable iff (!rst_n)
    (set_v != '0) |=> ((en_o & $past(set_v)) == $past(set_v)));

  // R4: bits written to the clear address are disabled next cycle.
  a_r4_enable_clr: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_v != '0) |=> ((en_o & $past(clr_v)) == '0));

  // R6: a write to the raw address never acknowledges.
  a_r6_raw_readonly: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && hit_raw) |-> (ack_o == '0));
endmodule

// File: rtl/errirq_hub.sv
`timescale 1ns/1ps
module errirq_hub
  import errirq_pkg::*;
#(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned DATA_W = 32,
  parameter logic [SRC_N-1:0] FATAL_MASK = 6'b01_0010
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SRC_N-1:0]  evt_i,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_we,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              err_irq_o,
  output logic              err_fatal_o
);
  srcvec_t raw_w, en_w, ack_w, live_w;

  errirq_bits i_bits (
    .clk   (clk),
    .rst_n (rst_n),
    .evt_i (evt_i),
    .ack_i (ack_w),
    .raw_o (raw_w)
  );

  errirq_regs #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) i_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_addr  (reg_addr),
    .reg_we    (reg_we),
    .reg_wdata (reg_wdata),
    .raw_i     (raw_w),
    .en_o      (en_w),
    .ack_o     (ack_w),
    .reg_rdata (reg_rdata)
  );

  assign live_w      = gate(raw_w, en_w);
  assign err_irq_o   = |live_w;
  assign err_fatal_o = |(live_w & FATAL_MASK);

  // R9: a fatal indication is always also an interrupt.
  a_r9_fatal_in_irq: assert property (@(posedge clk) disable iff (!rst_n)
    err_fatal_o |-> err_irq_o);

  // R8: the interrupt needs a latched bit and an enable.
  a_r8_irq_needs_src: assert property (@(posedge clk) disable iff (!rst_n)
    err_irq_o |-> (raw_w != '0 && en_w != '0));

  // R10: upper read bits stay zero.
  a_r10_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[DATA_W-1:SRC_N] == '0);
endmodule

// File: tb/test_errirq_hub.sv
`timescale 1ns/1ps
module test_errirq_hub;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  evt_i = '0;
  logic [11:0] reg_addr = '0;
  logic        reg_we = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        err_irq_o, err_fatal_o;

  int checks = 0;
  int errors = 0;
  logic [5:0] m_raw = '0;
  logic [5:0] m_en  = '0;

  always #2.5 clk = ~clk;

  errirq_hub i_errirq_hub (
    .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .reg_addr(reg_addr),
    .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .err_irq_o(err_irq_o), .err_fatal_o(err_fatal_o)
  );

  function automatic logic [31:0] exp_read(logic [11:0] a, logic [5:0] r, logic [5:0] e);
    case (a)
      12'h1C0: return {26'd0, r};
      12'h1C4: return {26'd0, r & e};
      12'h1C8, 12'h1CC: return {26'd0, e};
      default: return 32'd0;
    endcase
  endfunction

  function automatic logic exp_fatal(logic [5:0] r, logic [5:0] e);
    return (r[1] & e[1]) | (r[4] & e[4]);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_reads(string req);
    logic [11:0] addrs [5] = '{12'h1C0, 12'h1C4, 12'h1C8, 12'h1CC, 12'h1D0};
    for (int i = 0; i < 5; i++) begin
      reg_addr = addrs[i];
      #0.2;
      chk({req, " read"}, reg_rdata, exp_read(addrs[i], m_raw, m_en));
    end
    chk("R8 irq", {31'd0, err_irq_o}, {31'd0, |(m_raw & m_en)});
    chk("R9 fatal", {31'd0, err_fatal_o}, {31'd0, exp_fatal(m_raw, m_en)});
  endtask

  // Called right after a falling edge: drive, take one edge, update model.
  task automatic step(logic [5:0] e, logic we, logic [11:0] a, logic [31:0] d);
    logic [5:0] ack, st, cl;
    evt_i = e; reg_we = we; reg_addr = a; reg_wdata = d;
    ack = (we && a == 12'h1C4) ? d[5:0] : 6'd0;
    st  = (we && a == 12'h1C8) ? d[5:0] : 6'd0;
    cl  = (we && a == 12'h1CC) ? d[5:0] : 6'd0;
    @(posedge clk);
    m_raw = (m_raw & ~ack) | e;
    m_en  = (m_en | st) & ~cl;
    @(negedge clk);
    evt_i = '0; reg_we = 1'b0; reg_wdata = '0;
  endtask

  initial begin
    #(200000 * 5.0);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] rb;
    void'($urandom(32'h5EED_0017));
    repeat (3) @(negedge clk);
    check_reads("R1 reset");
    rst_n = 1'b1;
    @(negedge clk);

    // R2: event latches with enables off, and holds
    step(6'b10_0001, 1'b0, 12'h0, 32'h0);
    check_reads("R2 latch no enable");
    step(6'd0, 1'b0, 12'h0, 32'h0);
    check_reads("R2 sticky");

    // R3: enable set, R5 masked view
    step(6'd0, 1'b1, 12'h1C8, 32'hFFFF_FFC1);
    check_reads("R3 enable set");
    // R6: write to raw address has no effect
    step(6'd0, 1'b1, 12'h1C0, 32'h3F);
    check_reads("R6 raw write ignored");
    // R4: enable clear
    step(6'd0, 1'b1, 12'h1CC, 32'h1);
    check_reads("R4 enable clear");

    // R9: fatal path through bit 4 then bit 1
    step(6'b01_0010, 1'b1, 12'h1C8, 32'h3F);
    check_reads("R9 fatal enabled");
    step(6'd0, 1'b1, 12'h1CC, 32'h10);
    check_reads("R9 fatal bit1 only");

    // R7: event meets acknowledge of the same bit
    step(6'b00_0010, 1'b1, 12'h1C4, 32'h2);
    check_reads("R7 event wins");
    chk("R7 bit1 held", {31'd0, m_raw[1]}, 32'd1);

    // R6: read raw and write it back to acknowledge
    reg_addr = 12'h1C0; #0.2; rb = reg_rdata;
    step(6'd0, 1'b1, 12'h1C4, rb);
    check_reads("R6 readback ack");

    // Random mix
    for (int n = 0; n < 400; n++) begin
      logic [5:0] e;
      logic [11:0] a;
      logic we;
      e  = (($urandom % 4) == 0) ? 6'($urandom) : 6'd0;
      we = ($urandom % 2) == 1;
      case ($urandom % 5)
        0: a = 12'h1C0; 1: a = 12'h1C4; 2: a = 12'h1C8;
        3: a = 12'h1CC; default: a = 12'h1D0;
      endcase
      step(e, we, a, $urandom);
      check_reads("R5 random");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule